// File: doc/BRIEF.md
# Horizontal Sync Pulse Regenerator

This block turns an incoming horizontal sync into a clean output sync. The incoming sync has already been normalised to active-high, and the line period has already been measured outside the block. A watchdog down counter restarts on every rising edge of the input sync. Its restart value is the measured period plus a small margin, so while syncs arrive on time the counter never runs out. If a sync goes missing, the counter reaches zero. It then emits a substitution strobe and restarts itself, which fills the gap with a pulse in the expected place.

A two-bit mode input picks one of four output shapes:

- input passed through, with substitution pulses in the gaps;
- a fixed-width pulse started by each input edge or each substitution;
- a free-running pulse train;
- input passed through with substitution turned off.

In free-running mode the counter restarts from a separate free-run period, and input edges have no effect on it.

Top module: `hsync_regen`

## Requirements
- R1: A synchronous active-high reset clears the output to 0 and the stored input level to 0. It also loads the watchdog with the restart value for the current mode.
- R2: In mode 0, while rising input edges arrive no further apart than the restart value, the output equals the input sync delayed by exactly one clock.
- R3: In the sync-tracking modes (0, 1 and 3) the restart value is hper + floor(hper/16). An input rising edge, detected synchronously, restarts the counter. If no restart happens for restart+1 clocks, a substitution strobe is issued and the counter restarts. The strobes then repeat every restart+1 clocks.
- R4: Each trigger makes the output high for exactly `pulse_width` clocks, starting in the clock after the trigger. A trigger is a substitution strobe in modes 0, 1 and 2, plus an input rising edge in mode 1. A width of 0 produces no pulse.
- R5: In mode 1 the output is only the fixed-width pulse. The length of the input sync has no effect on it.
- R6: A trigger that arrives while a fixed-width pulse is still high restarts the pulse from its full width.
- R7: In mode 2 the counter restarts from `hfp`, input edges are ignored, and a pulse starts every hfp+1 clocks.
- R8: In mode 3 the output is the input delayed by one clock, and nothing is added while the input is missing.
- R9: An input rising edge in the same clock in which the counter is at zero wins. The counter restarts from the edge, and no substitution is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Active-high horizontal sync, polarity already normalised |
| hper | input | CNT_W | Measured line period in clocks |
| hfp | input | CNT_W | Free-running period in clocks, minus one |
| pulse_width | input | PW_W | Fixed pulse width in clocks |
| mode | input | 2 | 0 pass plus substitute, 1 fixed width, 2 free run, 3 pass only |
| hsync_out | output | 1 | Regenerated horizontal sync |

## Verification
Every mode is swept against every pulse width from a small set, under five sync patterns. Each pattern separates one behaviour:

- **Steady syncs inside the window:** show that nothing is inserted while syncs are regular.
- **Syncs that stop after five lines:** expose where the substitution strobes fall and how far apart they are.
- **Syncs spaced exactly one clock past the restart value:** show whether the edge or the zero count wins.
- **Syncs spaced far too widely:** mix real and substituted pulses.
- **Dense short syncs:** tell a restarting pulse apart from one that ignores triggers while it is high.

Expected waveforms come from arithmetic on the event times. Spot checks pin down the first substitution cycle, the number of free-run pulses, and the silence in mode 3.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    // Output format selection; encoding is fixed by the mode port.
    typedef enum logic [1:0] {
        MODE_PASS_SUB  = 2'b00,
        MODE_FIXED     = 2'b01,
        MODE_FREE      = 2'b10,
        MODE_PASS_ONLY = 2'b11
    } hsr_mode_e;

    // Input sync seen by the datapath: registered level and edge strobe.
    typedef struct packed {
        logic level;
        logic rise;
    } sync_evt_t;

    // Margin added to the measured period is hper >> MARGIN_SHIFT.
    localparam int MARGIN_SHIFT = 4;

    function automatic logic mode_free_run(hsr_mode_e m);
        return m == MODE_FREE;
    endfunction

    function automatic logic mode_substitutes(hsr_mode_e m);
        return m != MODE_PASS_ONLY;
    endfunction

    function automatic logic mode_edge_triggers(hsr_mode_e m);
        return m == MODE_FIXED;
    endfunction

endpackage

// File: rtl/hsr_sync_edge.sv
module hsr_sync_edge
    import hsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_in,
    output sync_evt_t evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_in;
    end

    assign evt.level = prev_q;
    assign evt.rise  = sync_in & ~prev_q;

endmodule

// File: rtl/hsr_watchdog.sv
module hsr_watchdog
    import hsr_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             free_run,
    input  logic             subst_en,
    input  logic [CNT_W-1:0] hper,
    input  logic [CNT_W-1:0] hfp,
    output logic             strobe
);
    localparam int RW = CNT_W + 1;

    logic [RW-1:0] cnt_q;
    logic [RW-1:0] reload;
    logic          at_zero;
    logic          sync_load;

    assign reload    = free_run ? {1'b0, hfp}
                                : {1'b0, hper} + RW'(hper >> MARGIN_SHIFT);
    assign at_zero   = (cnt_q == '0);
    assign sync_load = rise & ~free_run;
    assign strobe    = at_zero & ~sync_load & subst_en;

    always_ff @(posedge clk) begin
        if (rst)                       cnt_q <= reload;
        else if (sync_load || at_zero) cnt_q <= reload;
        else                           cnt_q <= cnt_q - RW'(1);
    end

    assert_sync_beats_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rise && !free_run) |-> !strobe);

    assert_reload_on_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && at_zero) |=> (cnt_q == $past(reload)));

    assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && !at_zero && !sync_load) |=> (cnt_q == $past(cnt_q) - RW'(1)));

endmodule

// File: rtl/hsr_pulse_timer.sv
module hsr_pulse_timer #(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig,
    input  logic [PW_W-1:0] width,
    output logic            active
);
    logic [PW_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                 left_q <= '0;
        else if (trig)           left_q <= width;
        else if (left_q != '0)   left_q <= left_q - PW_W'(1);
    end

    assign active = (left_q != '0);

    assert_pulse_starts_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && trig && width != '0) |=> active);

    assert_idle_stays_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && !trig && !active) |=> !active);

endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
    import hsr_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PW_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] hper,
    input  logic [CNT_W-1:0] hfp,
    input  logic [PW_W-1:0]  pulse_width,
    input  logic [1:0]       mode,
    output logic             hsync_out
);
    hsr_mode_e mode_e;
    sync_evt_t evt;
    logic      strobe;
    logic      trig;
    logic      pulse_on;

    assign mode_e = hsr_mode_e'(mode);

    hsr_sync_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .evt     (evt)
    );

    hsr_watchdog #(.CNT_W(CNT_W)) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .rise     (evt.rise),
        .free_run (mode_free_run(mode_e)),
        .subst_en (mode_substitutes(mode_e)),
        .hper     (hper),
        .hfp      (hfp),
        .strobe   (strobe)
    );

    assign trig = strobe | (evt.rise & mode_edge_triggers(mode_e));

    hsr_pulse_timer #(.PW_W(PW_W)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .trig   (trig),
        .width  (pulse_width),
        .active (pulse_on)
    );

    always_comb begin
        unique case (mode_e)
            MODE_PASS_SUB:  hsync_out = evt.level | pulse_on;
            MODE_FIXED:     hsync_out = pulse_on;
            MODE_FREE:      hsync_out = pulse_on;
            MODE_PASS_ONLY: hsync_out = evt.level;
            default:        hsync_out = 1'b0;
        endcase
    end

    assert_no_strobe_pass_only_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_PASS_ONLY) |-> !strobe);

endmodule

// File: tb/tb_hsync_regen.sv
module tb_hsync_regen;
    localparam int CW = 8;
    localparam int PW = 4;
    localparam int N  = 400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_in = 1'b0;
    logic [CW-1:0] hper = 8'd32;
    logic [CW-1:0] hfp  = 8'd20;
    logic [PW-1:0] pw   = '0;
    logic [1:0]    mode = 2'b00;
    logic          hsync_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bit s_arr  [0:N-1];
    bit lg_arr [0:N-1];
    bit ex_arr [0:N-1];

    hsync_regen #(.CNT_W(CW), .PW_W(PW)) dut (
        .clk         (clk),
        .rst         (rst),
        .sync_in     (sync_in),
        .hper        (hper),
        .hfp         (hfp),
        .pulse_width (pw),
        .mode        (mode),
        .hsync_out   (hsync_out)
    );

    always #4 clk = ~clk;

    task automatic check(bit ok, string tag, int act, int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    function automatic int ones(int lo, int hi);
        int c = 0;
        for (int i = lo; i <= hi; i++) c += lg_arr[i];
        return c;
    endfunction

    task automatic run(int m, int p, int per, int hi, int nsync);
        string tag;
        int    rv, last, t, bad, first;
        bit    rise, sub, trig, pulse;

        mode = m[1:0];
        pw = p[PW-1:0];
        rst = 1'b1;
        sync_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(hsync_out == 1'b0, "R1 output low in reset", int'(hsync_out), 0);

        for (int i = 0; i < N; i++) s_arr[i] = (i < nsync * per) && (i % per < hi);

        rst = 1'b0;
        for (int i = 0; i <= N; i++) begin
            if (i > 0) begin
                @(negedge clk);
                lg_arr[i-1] = hsync_out;
            end
            if (i < N) sync_in = s_arr[i];
        end
        sync_in = 1'b0;

        // Expected waveform from event arithmetic.
        rv = (m == 2) ? 20 : 32 + 32 / 16;
        last = -1;
        t = -1000;
        for (int i = 0; i < N; i++) begin
            rise = s_arr[i] && !(i > 0 && s_arr[i-1]);
            sub = 0;
            if (rise && m != 2) last = i;
            else if (i - last == rv + 1) begin
                last = i;
                sub = (m != 3);
            end
            trig = sub || (m == 1 && rise);
            if (trig) t = i;
            pulse = (i >= t) && (i < t + p);
            case (m)
                0: ex_arr[i] = s_arr[i] | pulse;
                3: ex_arr[i] = s_arr[i];
                default: ex_arr[i] = pulse;
            endcase
        end

        case (m)
            0: tag = "R2 R3 R4";
            1: tag = "R4 R5 R6";
            2: tag = "R4 R7";
            default: tag = "R8";
        endcase
        if (per == rv + 1) tag = {tag, " R9"};

        bad = 0;
        first = 0;
        for (int i = 0; i < N; i++) begin
            if (lg_arr[i] != ex_arr[i]) begin
                if (bad == 0) first = i;
                bad++;
            end
        end
        if (bad != 0)
            $display("  mode %0d width %0d period %0d first mismatch cycle %0d", m, p, per, first);
        check(bad == 0, tag, int'(lg_arr[first]), int'(ex_arr[first]));

        if (m == 0 && p == 1 && per == 20 && nsync == 5)
            check(!lg_arr[114] && lg_arr[115] && lg_arr[150], "R3 substitution at 115 and 150",
                  int'(lg_arr[115]) + int'(lg_arr[150]), 2);
        if (m == 2 && p == 1 && per == 20 && nsync == 1000)
            check(ones(0, N-1) == 19, "R7 free-run pulse count", ones(0, N-1), 19);
        if (m == 3 && per == 20 && nsync == 5)
            check(ones(84, N-1) == 0, "R8 silent after input stops", ones(84, N-1), 0);
        if (m == 2 && p == 0 && per == 20 && nsync == 1000)
            check(ones(0, N-1) == 0, "R4 zero width gives no pulse", ones(0, N-1), 0);
        if (m == 1 && p == 12 && per == 8)
            check(ones(0, N-1) == N, "R6 retrigger keeps output high", ones(0, N-1), N);
        if (m == 1 && p == 1 && per == 20 && nsync == 1000)
            check(ones(0, N-1) == 20, "R5 one clock per edge despite long input", ones(0, N-1), 20);
    endtask

    initial begin
        int widths [4] = '{0, 1, 5, 12};
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 4; w++) begin
                run(m, widths[w], 20, 4, 1000);
                run(m, widths[w], 20, 4, 5);
                run(m, widths[w], 35, 4, 1000);
                run(m, widths[w], 50, 4, 1000);
                run(m, widths[w], 8, 2, 1000);
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule